// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns the contents of a DRAM mode register into the stream of column addresses for one read or write burst. The mode word chooses the burst length, the beat order (wrapping sequential or XOR interleaved), the read latency and whether writes are cut to a single beat. The length, order and write rule are taken into the burst when a command is accepted, so a later change to the mode word leaves a burst in progress alone.

A command strobe carries the starting column and a read/write flag. From the next cycle the block offers one column per beat on a valid/ready stream. The block moves to the next beat only on a cycle where both valid and ready are high. While valid is high and ready is low, the column and last flag hold steady. A stop command, or a new accepted command, overrides the stream whatever the state of ready; the beat on offer is then dropped. Commands have no ready of their own and are always sampled. The decoded read latency and an illegal-mode flag are plain outputs that follow the mode word directly, for use by a downstream read-data pipeline.

Top module: `burst_colgen`

## Requirements
- R1: Length field mode_word[2:0] gives 000 = 1 beat, 001 = 2, 010 = 4 and 011 = 8. beat_last is high on the final beat only. beat_valid goes low after that beat's handshake.
- R2: In sequential order (mode_word[3] = 0), beat k carries the start column with its low log2(length) bits replaced by (start + k) modulo the length. The higher bits stay the same as the start column.
- R3: In interleaved order (mode_word[3] = 1), beat k carries the start column XOR k.
- R4: Length code 111 with sequential order is a full-page burst. The column counts up by one per beat, wraps from 511 to 0, and never raises beat_last. It runs until a stop or a new command.
- R5: mode_illegal is high when any of these holds: the length code is 100, 101 or 110; the length code is 111 with interleaved order; the latency field mode_word[6:4] is neither 010 nor 011; any of mode_word bits 7, 8, 10, 11, 12 or 13 is 1. Bits 13:12 are the bank-select lines.
- R6: rd_latency reads 2 when mode_word[6:4] = 010, 3 when it is 011, and 0 otherwise.
- R7: When mode_word[9] = 1, a write command (cmd_write = 1) gives a single beat with beat_last high. A read under the same mode still bursts at the programmed length.
- R8: cmd_stop without cmd_start makes beat_valid low in the next cycle.
- R9: An accepted cmd_start during a burst abandons that burst. The next cycle shows beat 0 of the new burst.
- R10: While beat_valid is high and beat_ready is low, and no command or stop arrives, beat_col and beat_last hold. The beat index advances only on a handshake.
- R11: cmd_start while mode_illegal is high is ignored: no burst begins, and a burst in progress continues unchanged.
- R12: After reset beat_valid and beat_last are low. The cycle after an accepted cmd_start shows beat_valid high and beat_col equal to cmd_col.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 14 | Mode register contents; bits 13:12 are bank select |
| cmd_start | input | 1 | Read or write command strobe |
| cmd_col | input | COL_W (9) | Starting column of the command |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_stop | input | 1 | Burst-stop command |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat column is on offer |
| beat_col | output | COL_W (9) | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |
| mode_illegal | output | 1 | mode_word holds a reserved or forbidden code |
| rd_latency | output | 2 | Read latency in cycles, 0 if reserved |

## Verification
The assertions check on every cycle that a stalled beat keeps its column, that stop empties the stream by the next cycle, that a command under an illegal mode starts nothing from idle, that the first beat carries the commanded column, that a full-page index wraps to zero, and that a legal mode always decodes a latency of 2 or 3. The beat orders can only be shown by the bench's scenarios, because each beat depends on the start column and the whole history of handshakes. The same holds for the placement of the last flag at each length, the single-beat write rule, restarts in mid-burst, and the full list of reserved mode codes. Those scenarios compare every output against a model built from the requirements, under directed cases and seeded random traffic.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int MODE_W = 14;

  typedef struct packed {
    logic [1:0] len_log2;
    logic       full_page;
    logic       interleave;
    logic       wr_single;
  } burst_cfg_t;
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
  import bcg_pkg::*;
#(
  parameter int LAT_W = 2
) (
  input  logic [MODE_W-1:0] mode_word,
  output burst_cfg_t        cfg,
  output logic              illegal,
  output logic [LAT_W-1:0]  rd_latency
);
  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       len_ok;
  logic       lat_ok;
  logic       zero_ok;

  assign len_code = mode_word[2:0];
  assign lat_code = mode_word[6:4];

  always_comb begin
    cfg            = '0;
    cfg.interleave = mode_word[3];
    cfg.wr_single  = mode_word[9];
    len_ok         = 1'b1;
    unique case (len_code)
      3'b000:  cfg.len_log2 = 2'd0;
      3'b001:  cfg.len_log2 = 2'd1;
      3'b010:  cfg.len_log2 = 2'd2;
      3'b011:  cfg.len_log2 = 2'd3;
      3'b111: begin
        cfg.full_page = 1'b1;
        len_ok        = !mode_word[3];
      end
      default: len_ok = 1'b0;
    endcase
  end

  always_comb begin
    lat_ok     = 1'b1;
    rd_latency = '0;
    unique case (lat_code)
      3'b010:  rd_latency = LAT_W'(2);
      3'b011:  rd_latency = LAT_W'(3);
      default: lat_ok = 1'b0;
    endcase
  end

  assign zero_ok = !(mode_word[7] | mode_word[8] | mode_word[10] |
                     mode_word[11] | mode_word[12] | mode_word[13]);
  assign illegal = !(len_ok && lat_ok && zero_ok);
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_write,
  input  logic             stop,
  input  logic             ready,
  input  burst_cfg_t       cfg,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] k,
  output burst_cfg_t       cfg_q,
  output logic             last
);
  localparam logic [COL_W-1:0] K_TOP = '1;

  burst_cfg_t       eff_cfg;
  logic [COL_W-1:0] span_end;

  always_comb begin
    eff_cfg = cfg;
    if (is_write && cfg.wr_single) begin
      eff_cfg.len_log2  = 2'd0;
      eff_cfg.full_page = 1'b0;
    end
  end

  assign span_end = (COL_W'(1) << cfg_q.len_log2) - COL_W'(1);
  assign last     = active && !cfg_q.full_page && (k == span_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      k      <= '0;
      cfg_q  <= '0;
    end else if (start_ok) begin
      active <= 1'b1;
      base   <= start_col;
      k      <= '0;
      cfg_q  <= eff_cfg;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && ready) begin
      if (last) active <= 1'b0;
      else      k      <= k + COL_W'(1);
    end
  end

  a_r4_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    active && cfg_q.full_page && ready && (k == K_TOP) && !start_ok && !stop
    |=> active && (k == '0));

  a_r4_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    active && cfg_q.full_page |-> !last);
endmodule

// File: rtl/bcg_addr_gen.sv
module bcg_addr_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] k,
  input  burst_cfg_t       cfg_q,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign mask    = cfg_q.full_page ? '1
                 : (COL_W'(1) << cfg_q.len_log2) - COL_W'(1);
  assign seq_col = (base & ~mask) | ((base + k) & mask);
  assign ilv_col = base ^ (k & mask);
  assign col     = cfg_q.interleave ? ilv_col : seq_col;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_start,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_write,
  input  logic              cmd_stop,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last,
  output logic              mode_illegal,
  output logic [LAT_W-1:0]  rd_latency
);
  burst_cfg_t       cfg;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] k;
  logic             start_ok;

  bcg_mode_decode #(.LAT_W(LAT_W)) i_dec (
    .mode_word (mode_word),
    .cfg       (cfg),
    .illegal   (mode_illegal),
    .rd_latency(rd_latency)
  );

  assign start_ok = cmd_start && !mode_illegal;

  bcg_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .start_col(cmd_col),
    .is_write (cmd_write),
    .stop     (cmd_stop),
    .ready    (beat_ready),
    .cfg      (cfg),
    .active   (beat_valid),
    .base     (base),
    .k        (k),
    .cfg_q    (cfg_q),
    .last     (beat_last)
  );

  bcg_addr_gen #(.COL_W(COL_W)) i_addr (
    .base (base),
    .k    (k),
    .cfg_q(cfg_q),
    .col  (beat_col)
  );

  a_r1_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !cmd_start && !cmd_stop
    |=> beat_valid && $stable(beat_col) && $stable(beat_last));

  a_r8_stop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_start |=> !beat_valid);

  a_r11_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && mode_illegal && !beat_valid |=> !beat_valid);

  a_r12_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !mode_illegal |=> beat_valid && (beat_col == $past(cmd_col)));

  a_r6_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_illegal |-> (rd_latency == LAT_W'(2)) || (rd_latency == LAT_W'(3)));
endmodule

// File: tb/test_burst_colgen.sv
module test_burst_colgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] mode_word = '0;
  logic        cmd_start = 1'b0;
  logic [8:0]  cmd_col = '0;
  logic        cmd_write = 1'b0;
  logic        cmd_stop = 1'b0;
  logic        beat_ready = 1'b0;
  logic        beat_valid;
  logic [8:0]  beat_col;
  logic        beat_last;
  logic        mode_illegal;
  logic [1:0]  rd_latency;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit       m_act = 0;
  bit [8:0] m_base = '0;
  bit [8:0] m_k = '0;
  int       m_log2 = 0;
  bit       m_full = 0;
  bit       m_ilv = 0;

  always #5 clk = ~clk;

  burst_colgen i_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cmd_start(cmd_start),
    .cmd_col(cmd_col), .cmd_write(cmd_write), .cmd_stop(cmd_stop),
    .beat_ready(beat_ready), .beat_valid(beat_valid), .beat_col(beat_col),
    .beat_last(beat_last), .mode_illegal(mode_illegal), .rd_latency(rd_latency)
  );

  function automatic logic [13:0] mw(input int bl, input int bt, input int cl, input int wb);
    logic [13:0] v = '0;
    v[2:0] = bl[2:0]; v[3] = bt[0]; v[6:4] = cl[2:0]; v[9] = wb[0];
    return v;
  endfunction

  function automatic bit f_illegal(input logic [13:0] w);
    bit bad = 0;
    if (w[2:0] inside {3'b100, 3'b101, 3'b110}) bad = 1;
    if (w[2:0] == 3'b111 && w[3]) bad = 1;
    if (!(w[6:4] inside {3'b010, 3'b011})) bad = 1;
    if (w[7] || w[8] || w[10] || w[11] || w[12] || w[13]) bad = 1;
    return bad;
  endfunction

  function automatic int f_lat(input logic [13:0] w);
    if (w[6:4] == 3'b010) return 2;
    if (w[6:4] == 3'b011) return 3;
    return 0;
  endfunction

  function automatic bit [8:0] f_col();
    int mask = m_full ? 511 : (1 << m_log2) - 1;
    int b = m_base;
    int kk = m_k;
    if (m_ilv) return 9'(b ^ kk);
    return 9'((b & ~mask) | ((b + kk) & mask));
  endfunction

  function automatic bit f_last();
    return m_act && !m_full && (int'(m_k) == (1 << m_log2) - 1);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input int c, input bit w, input bit sp, input bit rd,
                      input string tag);
    bit ex_last;
    cmd_start = s; cmd_col = 9'(c); cmd_write = w; cmd_stop = sp; beat_ready = rd;
    #1;
    chk(tag, "beat_valid", beat_valid, m_act);
    ex_last = f_last();
    chk(tag, "beat_last", beat_last, ex_last);
    if (m_act) chk(tag, "beat_col", beat_col, f_col());
    chk("R5", "mode_illegal", mode_illegal, f_illegal(mode_word));
    chk("R6", "rd_latency", rd_latency, f_lat(mode_word));
    if (s && !f_illegal(mode_word)) begin
      m_act = 1; m_base = 9'(c); m_k = '0;
      m_ilv = mode_word[3];
      m_full = (mode_word[2:0] == 3'b111);
      m_log2 = m_full ? 0 : int'(mode_word[1:0]);
      if (w && mode_word[9]) begin m_log2 = 0; m_full = 0; end
    end else if (sp) m_act = 0;
    else if (m_act && rd) begin
      if (ex_last) m_act = 0; else m_k = m_k + 9'd1;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit rd, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, rd, tag);
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode_word = mw(2, 0, 2, 0);
    // R12: reset state
    step(0, 0, 0, 0, 1, "R12");
    // R2 / R12: sequential length 4 wrapping inside the aligned block
    step(1, 'h0A6, 0, 0, 1, "R12");
    run(5, 1, "R2");
    // R1: lengths 1, 2 and 8
    mode_word = mw(0, 0, 3, 0); step(1, 'h033, 0, 0, 1, "R1"); run(2, 1, "R1");
    mode_word = mw(1, 0, 3, 0); step(1, 'h033, 0, 0, 1, "R1"); run(3, 1, "R1");
    mode_word = mw(3, 0, 2, 0); step(1, 'h10D, 0, 0, 1, "R1"); run(9, 1, "R2");
    // R3: interleaved length 8 and 4
    mode_word = mw(3, 1, 2, 0); step(1, 'h015, 0, 0, 1, "R3"); run(9, 1, "R3");
    mode_word = mw(2, 1, 3, 0); step(1, 'h1F6, 0, 0, 1, "R3"); run(5, 1, "R3");
    // R4 / R8: full page across 511 -> 0, then stop
    mode_word = mw(7, 0, 2, 0); step(1, 'h1FD, 0, 0, 1, "R4"); run(6, 1, "R4");
    step(0, 0, 0, 1, 1, "R8"); run(2, 1, "R8");
    // R5 / R11: reserved codes; starts ignored from idle and mid-burst
    for (int i = 0; i < 16; i++) begin
      case (i % 8)
        0: mode_word = mw(4, 0, 2, 0);
        1: mode_word = mw(5, 0, 3, 0);
        2: mode_word = mw(6, 1, 2, 0);
        3: mode_word = mw(7, 1, 2, 0);
        4: mode_word = mw(3, 0, 1, 0);
        5: mode_word = mw(3, 0, 4 + (i / 8), 0);
        6: mode_word = mw(1, 0, 2, 0) | (14'd1 << (7 + (i / 8)));
        default: mode_word = mw(1, 0, 3, 0) | (14'd1 << (10 + (i / 8) * 2));
      endcase
      step(1, 'h055, 0, 0, 1, "R11");
    end
    mode_word = mw(3, 0, 2, 0) | 14'h3000; step(0, 0, 0, 0, 1, "R5");
    mode_word = mw(3, 0, 3, 0); step(1, 'h080, 0, 0, 1, "R11");
    mode_word = mw(2, 0, 9, 0); step(1, 'h0FF, 0, 0, 1, "R11"); run(8, 1, "R11");
    // R6: latency codes
    mode_word = mw(2, 0, 0, 0); step(0, 0, 0, 0, 1, "R6");
    mode_word = mw(2, 0, 7, 0); step(0, 0, 0, 0, 1, "R6");
    // R7: single-beat writes, reads still burst
    mode_word = mw(3, 0, 2, 1); step(1, 'h044, 1, 0, 1, "R7"); run(2, 1, "R7");
    step(1, 'h044, 0, 0, 1, "R7"); run(9, 1, "R7");
    mode_word = mw(7, 0, 2, 1); step(1, 'h1FF, 1, 0, 1, "R7"); run(2, 1, "R7");
    // R9: restart mid-burst
    mode_word = mw(3, 0, 3, 0); step(1, 'h020, 0, 0, 1, "R9"); run(3, 1, "R9");
    mode_word = mw(2, 1, 3, 0); step(1, 'h107, 0, 0, 1, "R9"); run(5, 1, "R9");
    // R10: back-pressure
    mode_word = mw(2, 0, 2, 0); step(1, 'h0C3, 0, 0, 0, "R10");
    run(3, 0, "R10"); run(1, 1, "R10"); run(2, 0, "R10"); run(4, 1, "R10");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom;
      if (r[3:0] == 0) mode_word = 14'($urandom);
      else if (r[3:0] < 3)
        mode_word = mw(($urandom % 4) + (r[4] ? 0 : ($urandom % 2) * 7 / 7 * 0) + (r[5] && !r[6] ? 7 - ($urandom % 4) - (($urandom % 4)) * 0 : 0) % 8,
                       int'(r[6]), 2 + int'(r[7]), int'(r[8]));
      step(r[11:9] == 0, int'($urandom % 512), r[12], r[15:13] == 0, r[17:16] != 0, "R10");
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule